// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block raises a periodic interrupt for a processor subsystem. A small prescaler divides the system clock into count ticks, and each tick moves a 16-bit down-counter one step. When the counter finishes its run, the block issues a one-cycle interrupt pulse. In the same step it refills the counter from a period register, so the next interval starts without a dead cycle.

Software uses a plain register write port to set the period, the counter value, the prescale value and the run/stop control. The current counter value and the run state are visible on output ports. Interrupt masking, priority and any bus decoding beyond the select field are left to the surrounding logic.

Top module: `ivl_timer`

## Requirements
- R1: After reset the counter, period and prescale registers are zero, the timer is stopped (`running_o` = 0) and `irq_o` is low.
- R2: A write with `wr_en` high updates the register chosen by `wr_sel`: 0 = period, 1 = counter, 2 = prescale (low 8 bits of `wr_data` are kept and the rest is dropped), 3 = control (bit 0 = run, other bits ignored). The new value is visible on the following cycle.
- R3: With prescale value P, the counter decrements once every P+1 running cycles. Writing the prescale register restarts the prescale phase, so the first tick falls P+1 running cycles after that write.
- R4: The interrupt is a pulse of one cycle. It appears in the cycle after a tick that finds the counter at 1 (or 0). With period N ≥ 1, consecutive pulses are N·(P+1) cycles apart.
- R5: The tick that raises the interrupt also reloads the counter from the period register, so `count_o` equals the period while `irq_o` is high.
- R6: A period of 0 makes the interrupt fire on every prescaled tick, that is, every P+1 cycles.
- R7: While stopped, the prescale phase and the counter hold their values and no interrupt is raised. Counting resumes from the held state when the timer is started again.
- R8: A software write to the counter in the same cycle as a tick takes precedence. The counter takes the written value, and any interrupt that tick would have raised is suppressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 16 | Write data |
| irq_o | output | 1 | Interrupt pulse |
| count_o | output | 16 | Current counter value |
| running_o | output | 1 | Timer run state |

## Verification
The collision that matters here is a software counter write landing on the same edge as a prescaled tick, and in particular a tick that would otherwise finish the interval. The bench runs the prescaler at one tick per cycle with the counter at 1. It starts the timer and writes a new counter value on the very next edge. It then judges the result by `count_o` holding the written value rather than a reload or a decrement, and by `irq_o` staying low in the following cycle. A second, milder overlap is a period register write on the reload edge, which the checker watches by comparing the reloaded value with the period held before that edge.

// File: rtl/ivl_timer_pkg.sv
`timescale 1ns/1ps
package ivl_timer_pkg;

   // Register select codes on the write port.
   typedef enum logic [1:0] {
      SEL_PERIOD   = 2'd0,
      SEL_COUNT    = 2'd1,
      SEL_PRESCALE = 2'd2,
      SEL_CTRL     = 2'd3
   } ivl_sel_e;

   // Bit position of the run flag in the control word.
   localparam int CTRL_RUN_BIT = 0;

endpackage

// File: rtl/ivl_regs.sv
`timescale 1ns/1ps
module ivl_regs
   import ivl_timer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] period_q,
   output logic [PRE_W-1:0] prescale_q,
   output logic             run_q,
   output logic             cnt_load,
   output logic             pre_load,
   output logic [CNT_W-1:0] cnt_load_val,
   output logic [PRE_W-1:0] pre_load_val
);

   logic wr_period;
   logic wr_ctrl;

   always_comb begin
      wr_period    = wr_en && (wr_sel == SEL_PERIOD);
      cnt_load     = wr_en && (wr_sel == SEL_COUNT);
      pre_load     = wr_en && (wr_sel == SEL_PRESCALE);
      wr_ctrl      = wr_en && (wr_sel == SEL_CTRL);
      cnt_load_val = wr_data;
      pre_load_val = wr_data[PRE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q   <= '0;
         prescale_q <= '0;
         run_q      <= 1'b0;
      end else begin
         if (wr_period) period_q   <= wr_data;
         if (pre_load)  prescale_q <= pre_load_val;
         if (wr_ctrl)   run_q      <= wr_data[CTRL_RUN_BIT];
      end
   end

endmodule

// File: rtl/ivl_prescale.sv
`timescale 1ns/1ps
module ivl_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [PRE_W-1:0] load_val,
   input  logic [PRE_W-1:0] reload_val,
   output logic             tick
);

   logic [PRE_W-1:0] phase_q;

   // A prescale write in the same cycle restarts the phase and swallows the tick.
   assign tick = run && (phase_q == '0) && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (load) begin
         phase_q <= load_val;
      end else if (run) begin
         if (phase_q == '0) phase_q <= reload_val;
         else               phase_q <= phase_q - PRE_W'(1);
      end
   end

endmodule

// File: rtl/ivl_countdown.sv
`timescale 1ns/1ps
module ivl_countdown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit
);

   logic last_step;

   assign last_step = (cnt_q <= CNT_W'(1));
   assign hit       = tick && last_step && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick) begin
         if (last_step) cnt_q <= period;
         else           cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/ivl_timer.sv
`timescale 1ns/1ps
module ivl_timer #(
   parameter int CNT_W   = 16,
   parameter int PRE_W   = 8,
   parameter int SEL_W   = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             irq_o,
   output logic [CNT_W-1:0] count_o,
   output logic             running_o
);

   localparam int MIN_CNT_W = 2;

   if (CNT_W < MIN_CNT_W) begin : g_bad_cnt_w
      $error("ivl_timer: CNT_W must be at least %0d", MIN_CNT_W);
   end
   if (PRE_W < 1 || PRE_W > CNT_W) begin : g_bad_pre_w
      $error("ivl_timer: PRE_W must lie in 1..CNT_W");
   end
   if (SEL_W != 2) begin : g_bad_sel_w
      $error("ivl_timer: SEL_W must be 2");
   end

   logic [CNT_W-1:0] period_q;
   logic [PRE_W-1:0] prescale_q;
   logic             run_q;
   logic             cnt_load;
   logic             pre_load;
   logic [CNT_W-1:0] cnt_load_val;
   logic [PRE_W-1:0] pre_load_val;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   ivl_regs #(
      .CNT_W (CNT_W),
      .PRE_W (PRE_W),
      .SEL_W (SEL_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .period_q     (period_q),
      .prescale_q   (prescale_q),
      .run_q        (run_q),
      .cnt_load     (cnt_load),
      .pre_load     (pre_load),
      .cnt_load_val (cnt_load_val),
      .pre_load_val (pre_load_val)
   );

   ivl_prescale #(
      .PRE_W (PRE_W)
   ) u_prescale (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q),
      .load       (pre_load),
      .load_val   (pre_load_val),
      .reload_val (prescale_q),
      .tick       (tick)
   );

   ivl_countdown #(
      .CNT_W (CNT_W)
   ) u_countdown (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (cnt_load),
      .load_val (cnt_load_val),
      .period   (period_q),
      .cnt_q    (cnt_q),
      .hit      (hit)
   );

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = hit;
   end

   assign count_o   = cnt_q;
   assign running_o = run_q;

endmodule

// File: rtl/ivl_timer_chk.sv
`timescale 1ns/1ps
module ivl_timer_chk
   import ivl_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SEL_W   = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [SEL_W-1:0] wr_sel,
   input logic [CNT_W-1:0] wr_data,
   input logic             run_q,
   input logic             tick,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] period_q,
   input logic             irq_o
);

   logic cnt_wr;
   assign cnt_wr = wr_en && (wr_sel == SEL_COUNT);

   // R3: a tick without a write moves the counter down by one
   a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R7: stopped and not written, the counter keeps its value
   a_r7_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cnt_wr) |=> $stable(cnt_q));

   // R8: a counter write always lands
   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(wr_data)));

   if (IRQ_REG) begin : g_reg_checks
      // R7: no interrupt follows a stopped cycle
      a_r7_no_irq_stopped: assert property (@(posedge clk) disable iff (!rst_n)
         !run_q |=> !irq_o);

      // R8: a counter write suppresses the interrupt of that tick
      a_r8_write_kills_irq: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_wr |=> !irq_o);

      // R5: the interrupt cycle shows the period held before the reload edge
      a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (cnt_q == $past(period_q)));
   end

endmodule

bind ivl_timer ivl_timer_chk #(
   .CNT_W   (CNT_W),
   .SEL_W   (SEL_W),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .run_q    (run_q),
   .tick     (tick),
   .cnt_q    (cnt_q),
   .period_q (period_q),
   .irq_o    (irq_o)
);

// File: tb/ivl_timer_tb.sv
`timescale 1ns/1ps
module ivl_timer_tb_top;

   logic        clk;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [15:0] wr_data;
   logic        irq_o;
   logic [15:0] count_o;
   logic        running_o;

   int n_run;
   int n_fail;
   bit done;

   ivl_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .irq_o     (irq_o),
      .count_o   (count_o),
      .running_o (running_o)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at a negedge; drives one write across the next posedge, returns at the negedge after it.
   task automatic wr(input logic [1:0] sel, input logic [15:0] data);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = data;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Counts negedges until irq_o is seen; returns the count.
   task automatic wait_irq(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!irq_o && n < 5000);
   endtask

   task automatic t_reset();
      check(count_o == 16'd0, "R1 count", count_o, 0);
      check(irq_o == 1'b0, "R1 irq", irq_o, 0);
      check(running_o == 1'b0, "R1 run", running_o, 0);
   endtask

   // R3 R4 R5 R6: configure, start, time two interrupt intervals
   task automatic t_interval(input logic [15:0] pre_data, input int p, input int n, input string tag);
      int got;
      int exp;
      wr(2'd3, 16'h0000);
      wr(2'd0, 16'(n));
      wr(2'd1, 16'(n));
      wr(2'd2, pre_data);
      wr(2'd3, 16'h0001);
      exp = ((n == 0) ? 1 : n) * (p + 1);
      wait_irq(got);
      check(got == exp, {tag, " first interval"}, got, exp);
      check(count_o == 16'(n), "R5 reload on irq", count_o, n);
      if (exp > 1) begin
         @(negedge clk);
         check(irq_o == 1'b0, "R4 pulse one cycle", irq_o, 0);
         wait_irq(got);
         got = got + 1;
      end else begin
         wait_irq(got);
      end
      check(got == exp, {tag, " second interval"}, got, exp);
   endtask

   // R3: exact cycle of the first decrement after a prescale write
   task automatic t_phase();
      wr(2'd3, 16'h0000);
      wr(2'd0, 16'd20);
      wr(2'd1, 16'd20);
      wr(2'd2, 16'd3);
      wr(2'd3, 16'h0001);
      repeat (3) @(negedge clk);
      check(count_o == 16'd20, "R3 no tick before P+1", count_o, 20);
      @(negedge clk);
      check(count_o == 16'd19, "R3 tick at P+1", count_o, 19);
   endtask

   // R7 and R2 control bit: stop holds, restart resumes
   task automatic t_hold();
      logic [15:0] held;
      wr(2'd2, 16'd0);
      wr(2'd0, 16'd50);
      wr(2'd1, 16'd30);
      wr(2'd3, 16'h0001);
      repeat (4) @(negedge clk);
      wr(2'd3, 16'hFFFE);
      check(running_o == 1'b0, "R2 ctrl bit0 clears run", running_o, 0);
      held = count_o;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (count_o != held || irq_o) begin
            check(1'b0, "R7 hold while stopped", count_o, held);
            break;
         end
      end
      check(count_o == held, "R7 count held", count_o, held);
      wr(2'd1, 16'd1);
      check(count_o == 16'd1, "R7 write while stopped", count_o, 1);
      repeat (5) @(negedge clk);
      check(irq_o == 1'b0, "R7 no irq while stopped", irq_o, 0);
      wr(2'd3, 16'h0001);
      @(negedge clk);
      check(irq_o == 1'b1, "R7 resume from held state", irq_o, 1);
      check(count_o == 16'd50, "R5 reload after resume", count_o, 50);
   endtask

   // R8: counter write on the edge of an interval-ending tick
   task automatic t_collide();
      wr(2'd3, 16'h0000);
      wr(2'd2, 16'd0);
      wr(2'd0, 16'd5);
      wr(2'd1, 16'd1);
      wr(2'd3, 16'h0001);
      wr(2'd1, 16'd9);
      check(count_o == 16'd9, "R8 write wins count", count_o, 9);
      check(irq_o == 1'b0, "R8 irq suppressed", irq_o, 0);
      @(negedge clk);
      check(count_o == 16'd8, "R8 counting continues", count_o, 8);
   endtask

   initial begin
      int wd;
      for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      n_run   = 0;
      n_fail  = 0;
      done    = 1'b0;
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_sel  = 2'd0;
      wr_data = 16'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_interval(16'd0,    0,   3, "R4 P=0 N=3");
      t_interval(16'd2,    2,   3, "R3 P=2 N=3");
      t_interval(16'h0AFF, 255, 2, "R2 R3 prescale truncated P=255");
      t_interval(16'd1,    1,   0, "R6 period zero P=1");
      t_interval(16'd0,    0,   0, "R6 period zero P=0");
      t_phase();
      t_hold();
      t_collide();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule